// File: doc/BRIEF.md
# Synchronized Microcontroller Bus Slave

This block lets an external microcontroller read and write a small bank of registers over an asynchronous, multiplexed 16-bit address/data bus. The block runs entirely on one system clock (32 MHz, 31.25 ns period). No bus strobe drives a flip-flop clock pin. Every bus pin is oversampled through a two-flop register chain. Strobe edges are found by comparing the last synchronizer stage with a one-cycle delayed copy.

During a transfer the microcontroller first places a register index on the bus while the address strobe is high. Lowering that strobe latches the index. For a write, it puts data on the bus and pulses the active-low write strobe; the data is taken at the strobe's rising edge. For a read, it lowers the active-low read strobe, and the block then drives the selected register onto the bus until the strobe rises.

An active-low bus clear pin asynchronously empties the edge detectors and blocks every bus action until it has been sampled high on two clock edges.

Top module: `mcu_bus_slave`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) zeroes all eight registers and the latched index, and leaves the bus undriven afterwards.
- R2: A write happens only at a rising edge of `wr_n_i`. It stores the bus value sampled at the first clock edge that sees `wr_n_i` high after a low sample. The store lands two clock edges after that sample.
- R3: Only a falling edge of `ale_i` latches a register index. The index is bits [2:0] of the bus value sampled at the first clock edge that sees `ale_i` low after a high sample. Bus changes while `ale_i` stays low do not alter it.
- R4: A write changes only the register at the latched index (indices 0 to 7). All other registers keep their contents.
- R5: The block drives the register at the latched index onto `ad_io` after any clock edge that follows an edge at which `rd_n_i` and `ale_i` were both sampled low, provided the clear is inactive.
- R6: In every other case `ad_io` is high-impedance, including while `rd_n_i` is low but `ale_i` is high.
- R7: While `bus_clr_n` is low, and until it has been sampled high on two edges, strobe edges cause no write and no index latch, and the bus is not driven. The clear leaves register contents untouched, and its release causes no write.
- R8: Without a new `wr_n_i` rising edge, bus activity never changes a register. This holds however long `wr_n_i` stays high or low, as long as each strobe level is held for at least three clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 32 MHz |
| rst | input | 1 | Synchronous active-high reset |
| bus_clr_n | input | 1 | Asynchronous active-low bus clear |
| ale_i | input | 1 | Address strobe, index latched on its falling edge |
| wr_n_i | input | 1 | Active-low write strobe, data taken on its rising edge |
| rd_n_i | input | 1 | Active-low read strobe |
| ad_io | inout | 16 | Multiplexed address/data bus |

## Verification
The assertions watch the following on every cycle:
- each write pulse and each index-latch pulse lines up with the strobe pattern seen three and two cycles earlier;
- bus drive only ever follows a read-low, address-low sample two cycles back;
- the clear silences pulses and drive;
- the register bank holds still whenever there is no write pulse.

Only the bench scenarios can show that the right data reaches the right register. These cover:
- data alignment over a long write strobe;
- the index surviving bus changes;
- the clear release causing no spurious write;
- the float level seen when a read overlaps a high address strobe.

// File: rtl/mcu_bus_pkg.sv
`timescale 1ns/1ps
package mcu_bus_pkg;

    localparam int DEF_BUS_W       = 16;
    localparam int DEF_NUM_REGS    = 8;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    typedef struct packed {
        logic ale;
        logic wr_n;
        logic rd_n;
    } strobes_t;

    localparam strobes_t STROBE_IDLE = '{ale: 1'b0, wr_n: 1'b1, rd_n: 1'b1};

    function automatic logic edge_hit(edge_kind_e kind, logic cur, logic prev);
        logic changed;
        changed = cur ^ prev;
        return (kind == EDGE_RISE) ? (changed & cur) : (changed & ~cur);
    endfunction

endpackage

// File: rtl/bus_sync.sv
`timescale 1ns/1ps
module bus_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/strobe_edge.sv
`timescale 1ns/1ps
module strobe_edge
    import mcu_bus_pkg::*;
#(
    parameter edge_kind_e KIND = EDGE_RISE,
    parameter logic       IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    input  logic en,
    input  logic lvl,
    output logic pulse
);
    logic lvl_d;

    // delayed copy: emptied by the asynchronous bus clear, set idle by reset
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)   lvl_d <= 1'b0;
        else if (rst) lvl_d <= IDLE;
        else          lvl_d <= lvl;
    end

    assign pulse = en & edge_hit(KIND, lvl, lvl_d);
endmodule

// File: rtl/reg_bank.sv
`timescale 1ns/1ps
module reg_bank #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [IW-1:0]  widx,
    input  logic [W-1:0]   wdata,
    input  logic [IW-1:0]  ridx,
    output logic [W-1:0]   rdata,
    output logic [N*W-1:0] flat
);
    logic [W-1:0] q [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)                          q[g] <= '0;
                else if (we && widx == IW'(g))    q[g] <= wdata;
            end
            assign flat[g*W +: W] = q[g];
        end
    endgenerate

    assign rdata = q[ridx];
endmodule

// File: rtl/mcu_bus_slave.sv
`timescale 1ns/1ps
module mcu_bus_slave
    import mcu_bus_pkg::*;
#(
    parameter int BUS_W       = DEF_BUS_W,
    parameter int NUM_REGS    = DEF_NUM_REGS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_clr_n,
    input  logic             ale_i,
    input  logic             wr_n_i,
    input  logic             rd_n_i,
    inout  wire  [BUS_W-1:0] ad_io
);
    localparam int IDX_W = $clog2(NUM_REGS);

    strobes_t              strb_raw, strb;
    logic [BUS_W-1:0]      ad_s;
    logic [SYNC_STAGES-1:0] clr_chain;
    logic                  clr_ok;
    logic                  wr_pulse, ale_pulse;
    logic [IDX_W-1:0]      idx_q;
    logic [BUS_W-1:0]      rdata;
    logic [NUM_REGS*BUS_W-1:0] regs_flat;
    logic                  ad_oe;

    assign strb_raw = '{ale: ale_i, wr_n: wr_n_i, rd_n: rd_n_i};

    bus_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_strb_sync (
        .clk(clk), .rst(rst), .d(strb_raw), .q(strb)
    );

    // data chain has the same depth, so it stays aligned with the strobes
    bus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ad_sync (
        .clk(clk), .rst(rst), .d(ad_io), .q(ad_s)
    );

    // clear qualifier: dropped at once, restored after SYNC_STAGES edges
    always_ff @(posedge clk or negedge bus_clr_n) begin
        if (!bus_clr_n) clr_chain <= '0;
        else if (rst)   clr_chain <= '0;
        else            clr_chain <= {clr_chain[SYNC_STAGES-2:0], 1'b1};
    end
    assign clr_ok = clr_chain[SYNC_STAGES-1];

    strobe_edge #(.KIND(EDGE_RISE), .IDLE(1'b1)) u_wr_edge (
        .clk(clk), .rst(rst), .clr_n(bus_clr_n), .en(clr_ok),
        .lvl(strb.wr_n), .pulse(wr_pulse)
    );

    strobe_edge #(.KIND(EDGE_FALL), .IDLE(1'b0)) u_ale_edge (
        .clk(clk), .rst(rst), .clr_n(bus_clr_n), .en(clr_ok),
        .lvl(strb.ale), .pulse(ale_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst)            idx_q <= '0;
        else if (ale_pulse) idx_q <= ad_s[IDX_W-1:0];
    end

    reg_bank #(.W(BUS_W), .N(NUM_REGS), .IW(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .we(wr_pulse), .widx(idx_q), .wdata(ad_s),
        .ridx(idx_q), .rdata(rdata), .flat(regs_flat)
    );

    assign ad_oe = clr_ok & ~strb.rd_n & ~strb.ale;
    assign ad_io = ad_oe ? rdata : 'z;
endmodule

// File: rtl/mcu_bus_slave_chk.sv
`timescale 1ns/1ps
module mcu_bus_slave_chk #(
    parameter int BUS_W    = 16,
    parameter int NUM_REGS = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      clr_n,
    input logic                      ale_i,
    input logic                      wr_n_i,
    input logic                      rd_n_i,
    input logic                      wr_pulse,
    input logic                      ale_pulse,
    input logic                      ad_oe,
    input logic [NUM_REGS*BUS_W-1:0] regs_flat
);
    // R1
    reset_float_chk: assert property (@(posedge clk) disable iff (!clr_n)
        rst |=> !ad_oe);

    // R2
    wr_edge_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> (!$past(wr_n_i, 3) && $past(wr_n_i, 2)));

    // R3
    ale_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ale_pulse |-> ($past(ale_i, 3) && !$past(ale_i, 2)));

    // R5
    drive_src_chk: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (!$past(rd_n_i, 2) && !$past(ale_i, 2)));

    // R7
    clr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (!ad_oe && !wr_pulse && !ale_pulse));

    // R8
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_pulse |=> $stable(regs_flat));
endmodule

bind mcu_bus_slave mcu_bus_slave_chk #(.BUS_W(BUS_W), .NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst(rst), .clr_n(bus_clr_n), .ale_i(ale_i), .wr_n_i(wr_n_i),
    .rd_n_i(rd_n_i), .wr_pulse(wr_pulse), .ale_pulse(ale_pulse),
    .ad_oe(ad_oe), .regs_flat(regs_flat)
);

// File: tb/tb_mcu_bus_slave.sv
`timescale 1ns/1ps
module tb_mcu_bus_slave;
    localparam real CLK_PERIOD_NS = 31.25;
    localparam logic [15:0] FLOAT = 16'hFFFF;

    logic clk = 1'b0;
    logic rst, clr_n, ale, wr_n, rd_n, drv_en;
    logic [15:0] drv_val;
    wire  [15:0] ad_io;

    int total = 0;
    int bad   = 0;

    assign ad_io = drv_en ? drv_val : 'z;
    generate
        for (genvar i = 0; i < 16; i++) begin : g_pull
            pullup (ad_io[i]);
        end
    endgenerate

    mcu_bus_slave dut (
        .clk(clk), .rst(rst), .bus_clr_n(clr_n), .ale_i(ale),
        .wr_n_i(wr_n), .rd_n_i(rd_n), .ad_io(ad_io)
    );

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    typedef struct {
        bit          ale;
        bit          wr_n;
        bit          rd_n;
        bit          clr;
        logic [15:0] ad;
    } smp_t;

    smp_t        hist[$];
    logic [15:0] mreg [8];
    int          maddr;

    always @(posedge clk) begin
        smp_t now;
        now = '{ale: ale, wr_n: wr_n, rd_n: rd_n, clr: clr_n, ad: ad_io};
        if (rst) begin
            for (int i = 0; i < 8; i++) mreg[i] = '0;
            maddr = 0;
            hist.delete();
            for (int i = 0; i < 4; i++)
                hist.push_back('{ale: 1'b0, wr_n: 1'b1, rd_n: 1'b1, clr: 1'b0, ad: 16'h0});
        end else begin
            bit ok;
            hist.push_front(now);
            ok = hist[0].clr && hist[1].clr && hist[2].clr;
            if (ok && hist[2].wr_n && !hist[3].wr_n) mreg[maddr] = hist[2].ad;
            if (ok && !hist[2].ale && hist[3].ale)  maddr = int'(hist[2].ad[2:0]);
            while (hist.size() > 4) void'(hist.pop_back());
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the bus against the reference (R5, R6)
    always @(negedge clk) begin
        if (hist.size() >= 4) begin
            bit oe;
            logic [15:0] exp;
            oe  = hist[0].clr && hist[1].clr && clr_n && !hist[1].rd_n && !hist[1].ale;
            exp = oe ? mreg[maddr] : (drv_en ? drv_val : FLOAT);
            chk(oe ? "R5 cycle drive" : "R6 cycle float", ad_io, exp);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD_NS/4);
    endtask

    task automatic hold(int n);
        repeat (n) step();
    endtask

    task automatic bus_addr(int idx);
        drv_en = 1'b1; drv_val = 16'(idx);
        ale = 1'b1; hold(3);
        ale = 1'b0; hold(3);
        drv_en = 1'b0;
    endtask

    task automatic bus_write(int idx, logic [15:0] val);
        bus_addr(idx);
        drv_en = 1'b1; drv_val = val;
        wr_n = 1'b0; hold(3);
        wr_n = 1'b1; hold(3);
        drv_en = 1'b0; hold(1);
    endtask

    task automatic read_here(string tag, logic [15:0] exp);
        rd_n = 1'b0; hold(4);
        chk(tag, ad_io, exp);
        rd_n = 1'b1; hold(3);
    endtask

    task automatic bus_read(int idx, string tag, logic [15:0] exp);
        bus_addr(idx);
        read_here(tag, exp);
    endtask

    function automatic logic [15:0] pat(int i);
        return 16'hA5A5 ^ (16'(i) * 16'h1111);
    endfunction

    initial begin
        #(CLK_PERIOD_NS * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; clr_n = 1'b1; ale = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
        drv_en = 1'b0; drv_val = '0;
        hold(4);
        rst = 1'b0; hold(1);

        // R1: bus floats and every register reads zero after reset
        chk("R1 float after reset", ad_io, FLOAT);
        for (int i = 0; i < 8; i++) bus_read(i, "R1 reset value", 16'h0000);

        // R2, R4: distinct pattern into each register, read back all
        for (int i = 0; i < 8; i++) bus_write(i, pat(i));
        for (int i = 0; i < 8; i++) bus_read(i, "R4 readback", pat(i));

        // R2: extreme values
        bus_write(7, 16'hFFFE); bus_read(7, "R2 high value", 16'hFFFE);
        bus_write(7, 16'h0000); bus_read(7, "R2 zero value", 16'h0000);

        // R4: rewrite reg 3, neighbour reg 4 unchanged
        bus_write(3, 16'h3C3C);
        bus_read(4, "R4 neighbour kept", pat(4));
        bus_read(3, "R4 target written", 16'h3C3C);

        // R8: bus activity with WRN idle writes nothing
        drv_en = 1'b1; drv_val = 16'h7777; hold(6); drv_en = 1'b0; hold(1);
        bus_read(3, "R8 no write without edge", 16'h3C3C);

        // R2: long write strobe, data changing; value at rising edge wins
        bus_addr(0);
        drv_en = 1'b1; wr_n = 1'b0;
        for (int i = 0; i < 10; i++) begin drv_val = 16'h1000 + 16'(i); step(); end
        drv_val = 16'h0C0F; wr_n = 1'b1; hold(3);
        drv_en = 1'b0; hold(1);
        bus_read(0, "R2 long strobe capture", 16'h0C0F);

        // R3: bus changes while ALE stays low keep the index
        bus_addr(5);
        drv_en = 1'b1; drv_val = 16'h0002; hold(5); drv_en = 1'b0; hold(1);
        read_here("R3 index kept", pat(5));

        // R6: read low while ALE high leaves the bus floating
        bus_addr(1);
        rd_n = 1'b0; ale = 1'b1; hold(4);
        chk("R6 float during ALE high", ad_io, FLOAT);
        rd_n = 1'b1; hold(3);
        ale = 1'b0; hold(3);
        chk("R6 float when idle", ad_io, FLOAT);

        // R7: clear blocks writes, latches and drive; no write on release
        bus_write(6, 16'h6666);
        bus_read(2, "R7 before clear", pat(2));
        clr_n = 1'b0; hold(2);
        drv_en = 1'b1; drv_val = 16'h0006; ale = 1'b1; hold(3);
        ale = 1'b0; hold(3);
        drv_val = 16'hBEEF; wr_n = 1'b0; hold(3);
        wr_n = 1'b1; hold(3);
        drv_en = 1'b0;
        rd_n = 1'b0; hold(4);
        chk("R7 no drive during clear", ad_io, FLOAT);
        rd_n = 1'b1; hold(2);
        clr_n = 1'b1; hold(4);
        read_here("R7 index and data kept", pat(2));
        bus_read(6, "R7 other reg kept", 16'h6666);

        // R1: reset mid-run clears the bank
        rst = 1'b1; hold(2);
        rst = 1'b0; hold(1);
        chk("R1 float after second reset", ad_io, FLOAT);
        bus_read(5, "R1 cleared by reset", 16'h0000);
        bus_read(6, "R1 cleared by reset", 16'h0000);

        hold(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule